// File: doc/BRIEF.md
# Prescaled Dual Timer Mode Control

This block holds two 8-bit down-counters and one 8-bit mode register on a small register bus. The mode register gives each counter its own count source. A source is one of three taps of a free-running 9-bit divider of the system clock (every 512th, 256th or 4th cycle), or edges of an external clock input. The external input passes through a two-flop synchronizer. A separate input pin chooses whether its rising or its falling edges count. No derived clocks exist: every source becomes a one-cycle count enable in the system clock domain.

A start bit gates both counters. A cascade bit chains the second counter behind the underflows of the first, which makes one 16-bit timer. Each counter that decrements past zero comes back at 0xFF and sets a sticky underflow flag. Underflows of the second counter also flip a toggle that software can read in the mode register. A write to the mode register reloads both counters to 0xFF. The reload does not happen when the remote-control bit already held in the register is set.

Top module: `dual_timer_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, both counters read 0xFF and the flag register reads 0x00.
- R2: Register map: address 0 is the mode register, address 1 is counter A, address 2 is counter B, address 3 is the flags register (bit 0 = A underflow, bit 1 = B underflow). Mode bits 7:6 select the source of counter A, bit 5 is start, bit 4 is cascade, bits 3:2 select the source of counter B, bit 1 is the read-only toggle and bit 0 is remote mode. Writes to mode bit 1 are ignored. Writes to addresses 1 and 2 do nothing.
- R3: A write to address 0 sets both counters to 0xFF when mode bit 0 was 0 before the write. When mode bit 0 was 1 before the write, the counters keep their values.
- R4: Source code values: 00 = one count per 512 system clocks, 01 = one count per 256, 10 = one count per 4, 11 = external edges. Over any N·k consecutive cycles, tap k gives exactly N counts.
- R5: The external input is synchronized by two flops. When ext_fall_sel is 0 only rising edges count, and when it is 1 only falling edges count.
- R6: While mode bit 5 is 0, both counters hold their values.
- R7: A count at 0x00 gives 0xFF and sets that counter's flag. A flag stays set until a write to address 3 with a 1 in its bit position.
- R8: With mode bit 4 set, counter B decrements once per underflow of counter A and ignores its own source field.
- R9: Mode bit 1 reads an internal toggle that is 0 after reset and flips on every underflow of counter B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| ext_fall_sel | input | 1 | Edge select: 0 rising, 1 falling |

## Verification
A wrong source selection or tap decode shows up as a counter value that is off after a fixed number of cycles. An interval of 4N or 256N cycles must give an exact decrement, so a single read at the end of the interval shows the error. Faults in the reload, remote and start gating show up in the counter read that follows a mode write. Wrong wrap or cascade logic shows up only after 256 external edges, when the flags, counter B and the toggle bit are read.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic [1:0] {
    SRC_DIV512 = 2'b00,
    SRC_DIV256 = 2'b01,
    SRC_DIV4   = 2'b10,
    SRC_EXT    = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic slow;
    logic mid;
    logic fast;
  } taps_t;

  function automatic logic pick_source(input logic [1:0] sel, input taps_t t, input logic ext_evt);
    case (src_sel_e'(sel))
      SRC_DIV512: pick_source = t.slow;
      SRC_DIV256: pick_source = t.mid;
      SRC_DIV4:   pick_source = t.fast;
      default:    pick_source = ext_evt;
    endcase
  endfunction

  function automatic logic [7:0] step_down(input logic [7:0] v);
    step_down = (v == 8'h00) ? 8'hFF : v - 8'h01;
  endfunction
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
#(
  parameter int PW = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  output taps_t taps
);
  localparam int MID_W = PW - 1;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign taps.slow = &div_q;
  assign taps.mid  = &div_q[MID_W-1:0];
  assign taps.fast = &div_q[1:0];

  // R4: the slowest tap may fire only when the faster ones do
  assert_tap_nesting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taps.slow |-> (taps.mid && taps.fast));
  // R4: the fast tap never fires two cycles in a row
  assert_fast_tap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taps.fast |=> !taps.fast);
endmodule

// File: rtl/dtm_edge_sync.sv
module dtm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  // R5: a synchronized edge is never both directions at once
  assert_edge_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  // R5: edges alternate: no rising edge directly after a rising edge
  assert_edge_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dtm_counter.sv
module dtm_counter
  import dtm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         cnt_en,
  output logic [W-1:0] value,
  output logic         uflow
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q;

  assign uflow = cnt_en && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ALL_ONES;
    else if (load)   cnt_q <= ALL_ONES;
    else if (cnt_en) cnt_q <= W'(step_down(8'(cnt_q)));
  end

  assign value = cnt_q;

  // R3: a reload leaves the counter at all ones
  assert_reload_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value == ALL_ONES));
  // R6: no enable and no reload keeps the value
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(value));
  // R7: an underflow wraps to all ones
  assert_wrap_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (value == ALL_ONES));
endmodule

// File: rtl/dual_timer_ctrl.sv
module dual_timer_ctrl
  import dtm_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic         ext_clk_in,
  input  logic         ext_fall_sel
);
  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_CNTA  = 2'd1;
  localparam logic [1:0] A_CNTB  = 2'd2;
  localparam logic [1:0] A_FLAGS = 2'd3;

  logic [7:0]   mode_q;
  logic         toggle_q;
  logic [1:0]   flags_q;
  taps_t        taps;
  logic         ext_rise, ext_fall, ext_evt;
  logic         wr_mode, wr_flags, reload;
  logic         run, cascade, remote;
  logic         en_a, en_b, uf_a, uf_b;
  logic [W-1:0] cnt_a, cnt_b;

  assign run     = mode_q[5];
  assign cascade = mode_q[4];
  assign remote  = mode_q[0];

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
  assign reload   = wr_mode && !remote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 8'h00;
    else if (wr_mode) mode_q <= bus_wdata & 8'hFD;
  end

  dtm_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .taps(taps)
  );

  dtm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in),
    .rise(ext_rise), .fall(ext_fall)
  );

  assign ext_evt = ext_fall_sel ? ext_fall : ext_rise;
  assign en_a = run && pick_source(mode_q[7:6], taps, ext_evt);
  assign en_b = cascade ? uf_a : (run && pick_source(mode_q[3:2], taps, ext_evt));

  dtm_counter #(.W(W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .load(reload), .cnt_en(en_a),
    .value(cnt_a), .uflow(uf_a)
  );

  dtm_counter #(.W(W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .load(reload), .cnt_en(en_b),
    .value(cnt_b), .uflow(uf_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= 2'b00;
      toggle_q <= 1'b0;
    end else begin
      flags_q  <= (flags_q & ~(wr_flags ? bus_wdata[1:0] : 2'b00)) | {uf_b, uf_a};
      if (uf_b) toggle_q <= ~toggle_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {mode_q[7:2], toggle_q, mode_q[0]};
      A_CNTA:  bus_rdata = 8'(cnt_a);
      A_CNTB:  bus_rdata = 8'(cnt_b);
      default: bus_rdata = {6'b0, flags_q};
    endcase
  end

  // R9: the toggle moves only on an underflow of counter B
  assert_toggle_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_b |=> $stable(toggle_q));
  // R7: a flag raised by an underflow is visible on the next cycle
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |=> flags_q[0]);
  // R8: while cascaded, counter B moves only on an underflow of counter A
  assert_cascade_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !uf_a && !reload) |=> $stable(cnt_b));
  // R3: in remote mode a mode write leaves counter A untouched unless it counts
  assert_remote_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && remote && !en_a) |=> $stable(cnt_a));
  // R2: read-only bit never stored
  assert_bit1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> !mode_q[1]);
endmodule

// File: tb/dual_timer_ctrl_tb.sv
module dual_timer_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0;
  logic       ext_fall_sel = 1'b0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  dual_timer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .ext_fall_sel(ext_fall_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: pops one expected item per cycle and compares the read port
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests = tests + 1;
      if (bus_rdata !== e) begin
        fails = fails + 1;
        $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; idle(3);
      ext_clk_in = 1'b0; idle(3);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_rd(2'd0, 8'h00, "R1 mode");
    expect_rd(2'd1, 8'hFF, "R1 cntA");
    expect_rd(2'd2, 8'hFF, "R1 cntB");
    expect_rd(2'd3, 8'h00, "R1 flags");
    // R2 bit1 read-only, counter writes ignored
    wr(2'd0, 8'h02);
    expect_rd(2'd0, 8'h00, "R2 bit1 ignored");
    wr(2'd1, 8'h12);
    expect_rd(2'd1, 8'hFF, "R2 cnt write ignored");
    // R6 stopped counter holds
    wr(2'd0, 8'h80);
    idle(40);
    expect_rd(2'd1, 8'hFF, "R6 hold while stopped");
    // R4 divide by 4
    wr(2'd0, 8'hA0);
    idle(40);
    expect_rd(2'd1, 8'hF5, "R4 div4");
    // R4 divide by 256
    wr(2'd0, 8'h60);
    idle(512);
    expect_rd(2'd1, 8'hFD, "R4 div256");
    // R4 divide by 512
    wr(2'd0, 8'h20);
    idle(512);
    expect_rd(2'd1, 8'hFE, "R4 div512");
    expect_rd(2'd0, 8'h20, "R2 mode readback");
    // R5 rising edges
    ext_fall_sel = 1'b0;
    wr(2'd0, 8'hE0);
    pulses(3);
    expect_rd(2'd1, 8'hFC, "R5 rising count");
    // R5 falling edges only
    ext_fall_sel = 1'b1;
    wr(2'd0, 8'hE0);
    ext_clk_in = 1'b1; idle(6);
    expect_rd(2'd1, 8'hFF, "R5 rise ignored in fall mode");
    ext_clk_in = 1'b0; idle(6);
    expect_rd(2'd1, 8'hFE, "R5 falling count");
    // R3 remote mode blocks reload
    ext_fall_sel = 1'b0;
    wr(2'd0, 8'hE1);
    pulses(2);
    expect_rd(2'd1, 8'hFD, "R3 count in remote");
    wr(2'd0, 8'hE1);
    expect_rd(2'd1, 8'hFD, "R3 no reload in remote");
    wr(2'd0, 8'hE0);
    expect_rd(2'd1, 8'hFD, "R3 old remote bit rules");
    wr(2'd0, 8'hE0);
    expect_rd(2'd1, 8'hFF, "R3 reload outside remote");
    // R7 wrap and sticky flag
    expect_rd(2'd3, 8'h00, "R7 flags clear before");
    pulses(256);
    expect_rd(2'd1, 8'hFF, "R7 wrap to FF");
    expect_rd(2'd3, 8'h01, "R7 flag set");
    idle(5);
    expect_rd(2'd3, 8'h01, "R7 flag sticky");
    wr(2'd3, 8'h02);
    expect_rd(2'd3, 8'h01, "R7 other bit clear keeps flag");
    wr(2'd3, 8'h01);
    expect_rd(2'd3, 8'h00, "R7 flag cleared");
    // R8 cascade
    wr(2'd0, 8'hF0);
    pulses(256);
    expect_rd(2'd1, 8'hFF, "R8 low wrapped");
    expect_rd(2'd2, 8'hFE, "R8 high stepped once");
    expect_rd(2'd3, 8'h01, "R8 only low flag");
    expect_rd(2'd0, 8'hF0, "R9 toggle still 0");
    wr(2'd3, 8'h03);
    // R9 toggle on underflow of counter B (B on div4)
    wr(2'd0, 8'h28);
    idle(1024);
    expect_rd(2'd2, 8'hFF, "R9 cntB wrapped (R4 div4)");
    expect_rd(2'd0, 8'h2A, "R9 toggle set");
    expect_rd(2'd3, 8'h02, "R9 B flag");
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule